// File: doc/BRIEF.md
# Typed Predicate Define Unit

This unit turns one comparison outcome into updates for one or more predicate registers. Each destination slot has its own assignment kind. An unconditional kind always overwrites the destination. An OR-accumulating kind can only ever set the destination to TRUE. An AND-accumulating kind can only ever clear it to FALSE. Because the accumulating kinds leave the destination alone when their condition does not fire, a chain of defines that target one predicate computes a wide OR or AND. For that to work, software must preset OR targets to 0 and AND targets to 1.

The unit also carries deferred exceptions. If any source operand of the define holds a pending exception tag, the unit does not write a value. Instead it marks the destination as exceptional, keeps its old value, and drops its recovery tag. A define whose guard predicate is FALSE, or whose guard carries an exception tag, writes nothing. The comparison itself is done upstream, and the predicate storage sits downstream. The register file supplies the current value and recovery tag of each destination, and the unit returns registered write strobes one cycle after the define is presented.

Top module: `pred_define_unit`

## Requirements
- R1: While `rst_n` is low every `wr_en` bit is 0, and so are all other write fields. Reset acts without waiting for a clock.
- R2: Results appear on the `wr_*` outputs on the clock edge after the inputs are sampled with `def_vld` high. A cycle with `def_vld` low produces no write in the following cycle.
- R3: Kind bits [2:1] = 00 is unconditional. The destination is always written, with the effective condition as its value.
- R4: Kind bits [2:1] = 01 is OR-accumulating. The destination is written with 1 when the effective condition is true, and not written otherwise.
- R5: Kind bits [2:1] = 10 is AND-accumulating. The destination is written with 0 when the effective condition is false, and not written otherwise.
- R6: Kind bit 0 inverts the compare result to form the effective condition. This gives 000 set-on-true, 001 set-on-false, 010 or-on-true, 011 or-on-false, 100 and-on-true and 101 and-on-false.
- R7: When `grd_val` is 0, no destination is written, whatever its kind.
- R8: When `grd_exc` is 1, no destination is written, whatever the value of `grd_val`.
- R9: When the guard permits the define and any `src_exc` bit is set, every enabled lane with a non-reserved kind is written, regardless of kind or compare result. The write carries exception tag 1, recovery tag 0, and the lane's current value unchanged.
- R10: A normal write (no source exception) carries exception tag 0 and returns the lane's current recovery tag unchanged.
- R11: Kind bits [2:1] = 11 is reserved. A lane with a reserved kind never writes, not even on a source exception.
- R12: When two lanes would write the same predicate index, only the higher-numbered lane writes.
- R13: A lane whose `dst_en` bit is 0 never writes. Any lane not writing drives 0 on its index, value and both tag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| def_vld | input | 1 | A define operation is presented this cycle |
| cmp_res | input | 1 | Compare outcome from upstream |
| grd_val | input | 1 | Guard predicate value |
| grd_exc | input | 1 | Guard predicate exception tag |
| src_exc | input | NUM_SRC | Exception tags of the source operands |
| dst_en | input | NUM_DST | Per-lane destination present |
| dst_kind | input | NUM_DST x 3 | Per-lane assignment kind |
| dst_idx | input | NUM_DST x IDX_W | Per-lane destination predicate index |
| dst_cur_val | input | NUM_DST | Current value of each destination |
| dst_cur_rec | input | NUM_DST | Current recovery tag of each destination |
| wr_en | output | NUM_DST | Per-lane write strobe |
| wr_idx | output | NUM_DST x IDX_W | Per-lane write index |
| wr_val | output | NUM_DST | Per-lane new value |
| wr_exc | output | NUM_DST | Per-lane new exception tag |
| wr_rec | output | NUM_DST | Per-lane new recovery tag |

## Verification
A wrong internal decision shows up one cycle after the define as a write strobe on the wrong lane, or as a value or tag bit of the wrong polarity. No state lasts beyond that registered stage, so every fault appears on the very next edge or never. The vectors cover each kind against both compare outcomes. They also pair exception-carrying sources with kinds that would otherwise stay silent, and aim both lanes at one index to show the priority. Because an accumulating kind that should stay silent is checked through its strobe staying low, a unit that writes an unchanged value where it should write nothing is also caught.

// File: rtl/pdu_pkg.sv
package pdu_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [1:0] {
        CLS_UNC = 2'b00,
        CLS_OR  = 2'b01,
        CLS_AND = 2'b10,
        CLS_RSV = 2'b11
    } pdu_cls_e;

    function automatic pdu_cls_e kind_class(input logic [KIND_W-1:0] kind);
        return pdu_cls_e'(kind[2:1]);
    endfunction

    function automatic logic kind_inv(input logic [KIND_W-1:0] kind);
        return kind[0];
    endfunction

endpackage

// File: rtl/pdu_issue_qual.sv
module pdu_issue_qual #(
    parameter int NUM_SRC = 2
) (
    input  logic               def_vld,
    input  logic               grd_val,
    input  logic               grd_exc,
    input  logic [NUM_SRC-1:0] src_exc,
    output logic               fire,
    output logic               spec_exc
);

    always_comb begin
        // A guard carrying an exception suppresses the define outright.
        fire     = def_vld && grd_val && !grd_exc;
        spec_exc = |src_exc;
    end

endmodule

// File: rtl/pdu_lane_eval.sv
module pdu_lane_eval
    import pdu_pkg::*;
(
    input  logic              fire,
    input  logic              spec_exc,
    input  logic              cmp_res,
    input  logic              lane_en,
    input  logic [KIND_W-1:0] kind,
    input  logic              cur_val,
    input  logic              cur_rec,
    output logic              want,
    output logic              nxt_val,
    output logic              nxt_exc,
    output logic              nxt_rec
);

    pdu_cls_e cls;
    logic     eff;
    logic     fires_kind;
    logic     kind_val;

    always_comb begin
        cls = kind_class(kind);
        eff = cmp_res ^ kind_inv(kind);
        unique case (cls)
            CLS_UNC: begin fires_kind = 1'b1; kind_val = eff;  end
            CLS_OR:  begin fires_kind = eff;  kind_val = 1'b1; end
            CLS_AND: begin fires_kind = !eff; kind_val = 1'b0; end
            default: begin fires_kind = 1'b0; kind_val = 1'b0; end
        endcase

        want    = 1'b0;
        nxt_val = 1'b0;
        nxt_exc = 1'b0;
        nxt_rec = 1'b0;
        if (fire && lane_en && cls != CLS_RSV) begin
            if (spec_exc) begin
                // Deferred exception: tag it, keep the old value, drop recovery.
                want    = 1'b1;
                nxt_val = cur_val;
                nxt_exc = 1'b1;
                nxt_rec = 1'b0;
            end else if (fires_kind) begin
                want    = 1'b1;
                nxt_val = kind_val;
                nxt_exc = 1'b0;
                nxt_rec = cur_rec;
            end
        end
    end

endmodule

// File: rtl/pdu_dst_arbiter.sv
module pdu_dst_arbiter #(
    parameter int NUM_DST = 2,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_DST-1:0]            want,
    input  logic [NUM_DST-1:0][IDX_W-1:0] idx,
    output logic [NUM_DST-1:0]            grant
);

    always_comb begin
        for (int i = 0; i < NUM_DST; i++) begin
            logic shadowed;
            shadowed = 1'b0;
            for (int j = i + 1; j < NUM_DST; j++) begin
                if (want[j] && idx[j] == idx[i]) shadowed = 1'b1;
            end
            grant[i] = want[i] && !shadowed;
        end
    end

endmodule

// File: rtl/pred_define_unit.sv
module pred_define_unit
    import pdu_pkg::*;
#(
    parameter int NUM_DST = 2,
    parameter int NUM_SRC = 2,
    parameter int IDX_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           def_vld,
    input  logic                           cmp_res,
    input  logic                           grd_val,
    input  logic                           grd_exc,
    input  logic [NUM_SRC-1:0]             src_exc,
    input  logic [NUM_DST-1:0]             dst_en,
    input  logic [NUM_DST-1:0][KIND_W-1:0] dst_kind,
    input  logic [NUM_DST-1:0][IDX_W-1:0]  dst_idx,
    input  logic [NUM_DST-1:0]             dst_cur_val,
    input  logic [NUM_DST-1:0]             dst_cur_rec,
    output logic [NUM_DST-1:0]             wr_en,
    output logic [NUM_DST-1:0][IDX_W-1:0]  wr_idx,
    output logic [NUM_DST-1:0]             wr_val,
    output logic [NUM_DST-1:0]             wr_exc,
    output logic [NUM_DST-1:0]             wr_rec
);

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic             val;
        logic             exc;
        logic             rec;
    } wr_t;

    logic                fire;
    logic                spec_exc;
    logic [NUM_DST-1:0]  want;
    logic [NUM_DST-1:0]  grant;
    logic [NUM_DST-1:0]  l_val;
    logic [NUM_DST-1:0]  l_exc;
    logic [NUM_DST-1:0]  l_rec;

    wr_t [NUM_DST-1:0] wr_d;
    wr_t [NUM_DST-1:0] wr_q;

    pdu_issue_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .def_vld  (def_vld),
        .grd_val  (grd_val),
        .grd_exc  (grd_exc),
        .src_exc  (src_exc),
        .fire     (fire),
        .spec_exc (spec_exc)
    );

    for (genvar g = 0; g < NUM_DST; g++) begin : g_lane
        pdu_lane_eval u_eval (
            .fire     (fire),
            .spec_exc (spec_exc),
            .cmp_res  (cmp_res),
            .lane_en  (dst_en[g]),
            .kind     (dst_kind[g]),
            .cur_val  (dst_cur_val[g]),
            .cur_rec  (dst_cur_rec[g]),
            .want     (want[g]),
            .nxt_val  (l_val[g]),
            .nxt_exc  (l_exc[g]),
            .nxt_rec  (l_rec[g])
        );
    end

    pdu_dst_arbiter #(.NUM_DST(NUM_DST), .IDX_W(IDX_W)) u_arb (
        .want  (want),
        .idx   (dst_idx),
        .grant (grant)
    );

    always_comb begin
        for (int i = 0; i < NUM_DST; i++) begin
            wr_d[i] = '0;
            if (grant[i]) begin
                wr_d[i].en  = 1'b1;
                wr_d[i].idx = dst_idx[i];
                wr_d[i].val = l_val[i];
                wr_d[i].exc = l_exc[i];
                wr_d[i].rec = l_rec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_DST; i++) begin
            wr_en[i]  = wr_q[i].en;
            wr_idx[i] = wr_q[i].idx;
            wr_val[i] = wr_q[i].val;
            wr_exc[i] = wr_q[i].exc;
            wr_rec[i] = wr_q[i].rec;
        end
    end

endmodule

// File: rtl/pred_define_unit_chk.sv
module pred_define_unit_chk
    import pdu_pkg::*;
#(
    parameter int NUM_DST = 2,
    parameter int NUM_SRC = 2,
    parameter int IDX_W   = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           def_vld,
    input logic                           cmp_res,
    input logic                           grd_val,
    input logic                           grd_exc,
    input logic [NUM_SRC-1:0]             src_exc,
    input logic [NUM_DST-1:0]             dst_en,
    input logic [NUM_DST-1:0][KIND_W-1:0] dst_kind,
    input logic [NUM_DST-1:0][IDX_W-1:0]  dst_idx,
    input logic [NUM_DST-1:0]             dst_cur_val,
    input logic [NUM_DST-1:0]             dst_cur_rec,
    input logic [NUM_DST-1:0]             wr_en,
    input logic [NUM_DST-1:0][IDX_W-1:0]  wr_idx,
    input logic [NUM_DST-1:0]             wr_val,
    input logic [NUM_DST-1:0]             wr_exc,
    input logic [NUM_DST-1:0]             wr_rec
);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !def_vld |=> (wr_en == '0));

    p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (def_vld && !grd_val) |=> (wr_en == '0));

    p_grdexc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (def_vld && grd_exc) |=> (wr_en == '0));

    for (genvar i = 0; i < NUM_DST; i++) begin : g_lane_chk
        p_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (def_vld && grd_val && !grd_exc && (|src_exc))
            |=> (!wr_en[i] || (wr_exc[i] && !wr_rec[i])));

        p_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (def_vld && !(|src_exc) && dst_kind[i][2:1] == 2'b01)
            |=> (!wr_en[i] || wr_val[i]));

        p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (def_vld && !(|src_exc) && dst_kind[i][2:1] == 2'b10)
            |=> (!wr_en[i] || !wr_val[i]));

        p_rsv_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (def_vld && dst_kind[i][2:1] == 2'b11) |=> !wr_en[i]);

        p_dis_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (def_vld && !dst_en[i]) |=> !wr_en[i]);

        p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[i] |-> (wr_idx[i] == '0 && !wr_val[i] && !wr_exc[i] && !wr_rec[i]));

        for (genvar j = i + 1; j < NUM_DST; j++) begin : g_pair
            p_uniq_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[i] && wr_en[j]) |-> (wr_idx[i] != wr_idx[j]));
        end
    end

endmodule

bind pred_define_unit pred_define_unit_chk #(
    .NUM_DST(NUM_DST), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .def_vld(def_vld), .cmp_res(cmp_res),
    .grd_val(grd_val), .grd_exc(grd_exc), .src_exc(src_exc),
    .dst_en(dst_en), .dst_kind(dst_kind), .dst_idx(dst_idx),
    .dst_cur_val(dst_cur_val), .dst_cur_rec(dst_cur_rec),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .wr_exc(wr_exc), .wr_rec(wr_rec)
);

// File: tb/pred_define_unit_bench.sv
module pred_define_unit_bench;

    localparam int NUM_DST = 2;
    localparam int NUM_SRC = 2;
    localparam int IDX_W   = 6;

    localparam logic [2:0] K_UT = 3'b000, K_UF = 3'b001, K_OT = 3'b010,
                           K_OF = 3'b011, K_AT = 3'b100, K_AF = 3'b101,
                           K_RS = 3'b110;

    typedef struct packed {
        logic [31:0]      tag;
        logic             gv;
        logic             ge;
        logic [1:0]       se;
        logic             c;
        logic [1:0]       en;
        logic [2:0]       k1;
        logic [2:0]       k0;
        logic [IDX_W-1:0] i1;
        logic [IDX_W-1:0] i0;
        logic [1:0]       cv;
        logic [1:0]       cr;
        logic [1:0]       x_en;
        logic [1:0]       x_val;
        logic [1:0]       x_exc;
        logic [1:0]       x_rec;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        // tag    gv    ge    se     c     en     k1    k0    i1     i0     cv     cr     x_en   x_val  x_exc  x_rec
        '{"R3  ",1'b1,1'b0,2'b00,1'b1,2'b11,K_UF,K_UT,6'd5, 6'd4, 2'b00,2'b00,2'b11,2'b01,2'b00,2'b00},
        '{"R6  ",1'b1,1'b0,2'b00,1'b0,2'b11,K_UF,K_UT,6'd5, 6'd4, 2'b00,2'b00,2'b11,2'b10,2'b00,2'b00},
        '{"R4  ",1'b1,1'b0,2'b00,1'b1,2'b11,K_OF,K_OT,6'd2, 6'd1, 2'b00,2'b00,2'b01,2'b01,2'b00,2'b00},
        '{"R6  ",1'b1,1'b0,2'b00,1'b0,2'b11,K_OF,K_OT,6'd2, 6'd1, 2'b00,2'b00,2'b10,2'b10,2'b00,2'b00},
        '{"R5  ",1'b1,1'b0,2'b00,1'b0,2'b11,K_AF,K_AT,6'd2, 6'd1, 2'b11,2'b00,2'b01,2'b00,2'b00,2'b00},
        '{"R6  ",1'b1,1'b0,2'b00,1'b1,2'b11,K_AF,K_AT,6'd2, 6'd1, 2'b11,2'b00,2'b10,2'b00,2'b00,2'b00},
        '{"R7  ",1'b0,1'b0,2'b00,1'b1,2'b11,K_UT,K_UT,6'd2, 6'd1, 2'b00,2'b00,2'b00,2'b00,2'b00,2'b00},
        '{"R8  ",1'b1,1'b1,2'b11,1'b1,2'b11,K_UT,K_UT,6'd2, 6'd1, 2'b00,2'b00,2'b00,2'b00,2'b00,2'b00},
        '{"R9  ",1'b1,1'b0,2'b01,1'b1,2'b11,K_AT,K_OT,6'd7, 6'd3, 2'b10,2'b11,2'b11,2'b10,2'b11,2'b00},
        '{"R11 ",1'b1,1'b0,2'b10,1'b0,2'b11,K_UT,K_RS,6'd7, 6'd3, 2'b00,2'b00,2'b10,2'b00,2'b10,2'b00},
        '{"R10 ",1'b1,1'b0,2'b00,1'b1,2'b11,K_UT,K_UT,6'd8, 6'd6, 2'b00,2'b10,2'b11,2'b11,2'b00,2'b10},
        '{"R12 ",1'b1,1'b0,2'b00,1'b1,2'b11,K_UF,K_UT,6'd9, 6'd9, 2'b00,2'b00,2'b10,2'b00,2'b00,2'b00},
        '{"R12 ",1'b1,1'b0,2'b00,1'b0,2'b11,K_OT,K_UF,6'd9, 6'd9, 2'b00,2'b01,2'b01,2'b01,2'b00,2'b01},
        '{"R13 ",1'b1,1'b0,2'b00,1'b1,2'b00,K_UT,K_UT,6'd2, 6'd1, 2'b00,2'b00,2'b00,2'b00,2'b00,2'b00},
        '{"R13 ",1'b1,1'b0,2'b00,1'b1,2'b10,K_UT,K_UT,6'd63,6'd1, 2'b00,2'b00,2'b10,2'b10,2'b00,2'b00}
    };

    logic                          clk;
    logic                          rst_n;
    logic                          def_vld;
    logic                          cmp_res;
    logic                          grd_val;
    logic                          grd_exc;
    logic [NUM_SRC-1:0]            src_exc;
    logic [NUM_DST-1:0]            dst_en;
    logic [NUM_DST-1:0][2:0]       dst_kind;
    logic [NUM_DST-1:0][IDX_W-1:0] dst_idx;
    logic [NUM_DST-1:0]            dst_cur_val;
    logic [NUM_DST-1:0]            dst_cur_rec;
    logic [NUM_DST-1:0]            wr_en;
    logic [NUM_DST-1:0][IDX_W-1:0] wr_idx;
    logic [NUM_DST-1:0]            wr_val;
    logic [NUM_DST-1:0]            wr_exc;
    logic [NUM_DST-1:0]            wr_rec;

    int n_cmp;
    int n_bad;

    pred_define_unit #(.NUM_DST(NUM_DST), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pred_define_unit (
        .clk(clk), .rst_n(rst_n), .def_vld(def_vld), .cmp_res(cmp_res),
        .grd_val(grd_val), .grd_exc(grd_exc), .src_exc(src_exc),
        .dst_en(dst_en), .dst_kind(dst_kind), .dst_idx(dst_idx),
        .dst_cur_val(dst_cur_val), .dst_cur_rec(dst_cur_rec),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .wr_exc(wr_exc), .wr_rec(wr_rec)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic drive(input vec_t v, input logic vld);
        def_vld        = vld;
        grd_val        = v.gv;
        grd_exc        = v.ge;
        src_exc        = v.se;
        cmp_res        = v.c;
        dst_en         = v.en;
        dst_kind[1]    = v.k1;
        dst_kind[0]    = v.k0;
        dst_idx[1]     = v.i1;
        dst_idx[0]     = v.i0;
        dst_cur_val    = v.cv;
        dst_cur_rec    = v.cr;
    endtask

    task automatic compare(input string what, input vec_t v);
        logic [2*IDX_W+7:0] act;
        logic [2*IDX_W+7:0] exp;
        logic [IDX_W-1:0]   e1;
        logic [IDX_W-1:0]   e0;
        e1  = v.x_en[1] ? v.i1 : '0;
        e0  = v.x_en[0] ? v.i0 : '0;
        act = {wr_en, wr_idx[1], wr_idx[0], wr_val, wr_exc, wr_rec};
        exp = {v.x_en, e1, e0, v.x_val, v.x_exc, v.x_rec};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic vec_t quiet(input vec_t v);
        vec_t q;
        q       = v;
        q.x_en  = 2'b00;
        q.x_val = 2'b00;
        q.x_exc = 2'b00;
        q.x_rec = 2'b00;
        return q;
    endfunction

    initial begin
        n_cmp = 0;
        n_bad = 0;
        rst_n = 1'b0;
        drive(VEC[0], 1'b1);
        repeat (3) @(negedge clk);
        compare("R1 reset state", quiet(VEC[0]));
        rst_n = 1'b1;
        drive(VEC[0], 1'b0);

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k], 1'b1);
            @(negedge clk);
            compare($sformatf("%s vector %0d", VEC[k].tag, k), VEC[k]);
        end

        // R2: same stimulus without def_vld yields no write
        drive(VEC[0], 1'b0);
        @(negedge clk);
        compare("R2 no valid", quiet(VEC[0]));

        // R2: a valid define after an idle cycle appears one edge later
        drive(VEC[10], 1'b1);
        @(negedge clk);
        compare("R2 latency", VEC[10]);

        // R1: asynchronous reset clears pending writes before any edge
        drive(VEC[10], 1'b1);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        compare("R1 async reset", quiet(VEC[10]));
        @(negedge clk);
        rst_n = 1'b1;
        drive(VEC[0], 1'b0);
        @(negedge clk);
        compare("R1 after release", quiet(VEC[0]));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule